// File: doc/BRIEF.md
# Flash Sector Lock and Identifier Unit

This unit keeps one lock bit for each of the 19 sectors of a flash array and answers identifier reads. A host sends decoded write cycles, each an address and a data byte. A lock or release command takes effect only while the reset pin of the device is held at its high-voltage level, which the block sees as a single flag. While that flag is high, a lock check also lets the program/erase engine into locked sectors. The lock bits themselves stay untouched, so every lock is back in force once the flag drops.

Reads return a 16-bit identifier or status value one cycle after the request. The program/erase engine asks before each operation whether the addressed sector may be altered, and the answer comes back one cycle later as a grant or a reject. A parameter selects whether the small sectors sit at the top or the bottom of the address space. Address bits 18 down to 12 of the 19-bit word address select the sector.

Top module: `sect_guard`

## Requirements
- R1: After reset every sector is unlocked, and rd_valid, rd_data, pe_grant and pe_reject are all zero.
- R2: With TOP_BOOT=1, word addresses 00000h–77FFFh form sectors 0–14 of 8000h words each. Sector 15 is 78000h–7BFFFh, sector 16 is 7C000h–7CFFFh, sector 17 is 7D000h–7DFFFh and sector 18 is 7E000h–7FFFFh. With TOP_BOOT=0 the layout is mirrored: sector 0 is 00000h–01FFFh, sector 1 is 02000h–02FFFh, sector 2 is 03000h–03FFFh, sector 3 is 04000h–07FFFh, and sector n≥4 starts at (n−3)·8000h.
- R3: Writes while hv_reset is low change no lock. Dropping hv_reset closes any open command sequence and drops a pending verify.
- R4: With hv_reset high, a write of 60h at an address with bit6=0, bit1=1, bit0=0 locks that address's sector from the next cycle on. The write also opens a command sequence.
- R5: With hv_reset high, a write of 60h with bit6=1, bit1=1, bit0=0 clears all 19 locks if all 19 were set before the write. Otherwise it changes nothing. In either case it opens a command sequence.
- R6: With hv_reset high and a sequence open, a write of 40h with bit1=1, bit0=0 arms a verify for that exact address. The first read after that consumes the arm. If that read is at the armed address it returns 0001h when the sector is locked and 0000h when it is not. A 40h write with no open sequence does nothing.
- R7: A read with no matching verify and address bit6=0 decodes bit1:bit0. 00 returns 0001h. 01 returns the device code, which is 22DAh (top) or 225Bh (bottom) with byte_mode=0, and 00DAh or 005Bh with byte_mode=1. 10 returns 0001h or 0000h for the addressed sector's lock. 11 returns 0000h. With bit6=1 the read returns 0000h.
- R8: rd_valid is high exactly one cycle after rd_en, carrying the result. rd_data is 0000h in every cycle where rd_valid is low.
- R9: A write of F0h while hv_reset is high closes the command sequence and drops a pending verify. No lock changes.
- R10: A pe_req gives, one cycle later, pe_grant=1 if the sector is unlocked or hv_reset was high, and pe_reject=1 otherwise. With no request both are 0, and requests never change a lock.
- R11: Locks granted over during hv_reset are rejected again as soon as hv_reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hv_reset | input | 1 | Reset pin is at the high-voltage level |
| byte_mode | input | 1 | 1 selects byte-wide identifier format |
| wr_en | input | 1 | Write cycle strobe |
| wr_addr | input | 19 | Write word address |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read request |
| rd_addr | input | 19 | Read word address |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 16 | Identifier or status value |
| pe_req | input | 1 | Program/erase permission request |
| pe_addr | input | 19 | Address of the requested operation |
| pe_grant | output | 1 | Operation allowed |
| pe_reject | output | 1 | Operation refused, sector locked |

## Verification
Several rules are checked on every cycle: no lock moves without the high-voltage flag, a refused release leaves the locks stable, a lock command sets its sector's bit, a verify arm is consumed by the next read, reads answer with one cycle of latency, and a locked sector without the flag is always rejected. Other behaviour needs whole command sequences, so only the bench scenarios can show it. This covers the sector boundaries of the address map, the all-locked precondition for a release, the restoring of locks when the flag falls, and the identifier values in both width modes.

// File: rtl/sg_pkg.sv
package sg_pkg;
    localparam int ADDR_W  = 19;
    localparam int NSECT   = 19;
    localparam int SECT_W  = $clog2(NSECT);
    localparam int DATA_W  = 16;
    localparam int HI_W    = 7;

    localparam logic [7:0] OP_SETUP  = 8'h60;
    localparam logic [7:0] OP_VERIFY = 8'h40;
    localparam logic [7:0] OP_EXIT   = 8'hF0;

    localparam logic [7:0] MFR_CODE  = 8'h01;
    localparam logic [7:0] DEV_HI    = 8'h22;
    localparam logic [7:0] DEV_TOP   = 8'hDA;
    localparam logic [7:0] DEV_BOT   = 8'h5B;

    typedef logic [SECT_W-1:0] sect_t;
    typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/sg_sector_map.sv
module sg_sector_map
    import sg_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b1
) (
    input  addr_t addr,
    output sect_t sect
);
    logic [HI_W-1:0] hi;
    assign hi = addr[ADDR_W-1 -: HI_W];

    generate
        if (TOP_BOOT) begin : g_top
            always_comb begin
                if (hi[6:3] != 4'hF)   sect = sect_t'(hi[6:3]);
                else if (!hi[2])       sect = sect_t'(15);
                else if (!hi[1])       sect = hi[0] ? sect_t'(17) : sect_t'(16);
                else                   sect = sect_t'(18);
            end
        end else begin : g_bot
            always_comb begin
                if (hi[6:3] != 4'h0)   sect = sect_t'(hi[6:3]) + sect_t'(3);
                else if (hi[2])        sect = sect_t'(3);
                else if (hi[1])        sect = hi[0] ? sect_t'(2) : sect_t'(1);
                else                   sect = sect_t'(0);
            end
        end
    endgenerate
endmodule

// File: rtl/sg_cmd.sv
module sg_cmd
    import sg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hv_reset,
    input  logic             wr_en,
    input  addr_t            wr_addr,
    input  logic [7:0]       wr_data,
    input  sect_t            wr_sect,
    input  logic             rd_en,
    output logic [NSECT-1:0] lock_o,
    output logic             vfy_o,
    output addr_t            vaddr_o
);
    typedef struct packed {
        logic [NSECT-1:0] lock;
        logic             seq;
        logic             vfy;
        addr_t            vaddr;
    } cmd_st_t;

    cmd_st_t st_d, st_q;
    logic    pat_ok, a6, all_locked;

    assign pat_ok     = wr_addr[1] & ~wr_addr[0];
    assign a6         = wr_addr[6];
    assign all_locked = &st_q.lock;

    always_comb begin
        st_d = st_q;
        if (rd_en && st_q.vfy) st_d.vfy = 1'b0;
        if (!hv_reset) begin
            st_d.seq = 1'b0;
            st_d.vfy = 1'b0;
        end else if (wr_en) begin
            unique case (wr_data)
                OP_SETUP: if (pat_ok) begin
                    st_d.seq = 1'b1;
                    if (!a6)             st_d.lock[wr_sect] = 1'b1;
                    else if (all_locked) st_d.lock = '0;
                end
                OP_VERIFY: if (pat_ok && st_q.seq) begin
                    st_d.vfy   = 1'b1;
                    st_d.vaddr = wr_addr;
                end
                OP_EXIT: begin
                    st_d.seq = 1'b0;
                    st_d.vfy = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_o  = st_q.lock;
    assign vfy_o   = st_q.vfy;
    assign vaddr_o = st_q.vaddr;

    // R3
    no_cmd_without_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_reset |=> $stable(st_q.lock));
    // R5
    refused_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_reset && wr_en && wr_data == OP_SETUP && pat_ok && a6 && !all_locked)
        |=> $stable(st_q.lock));
    // R4
    lock_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_reset && wr_en && wr_data == OP_SETUP && pat_ok && !a6)
        |=> st_q.lock[$past(wr_sect)]);
    // R6
    verify_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st_q.vfy && !wr_en) |=> !st_q.vfy);
endmodule

// File: rtl/sg_rdmux.sv
module sg_rdmux
    import sg_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  addr_t             rd_addr,
    input  sect_t             rd_sect,
    input  logic              byte_mode,
    input  logic [NSECT-1:0]  lock,
    input  logic              vfy,
    input  addr_t             vaddr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [7:0] DEV_LO = TOP_BOOT ? DEV_TOP : DEV_BOT;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_st_t;

    rd_st_t rd_d, rd_q;
    logic   sect_lock;

    assign sect_lock = lock[rd_sect];

    always_comb begin
        rd_d = '0;
        if (rd_en) begin
            rd_d.valid = 1'b1;
            if (vfy && rd_addr == vaddr) begin
                rd_d.data = {{(DATA_W-1){1'b0}}, sect_lock};
            end else if (!rd_addr[6]) begin
                unique case (rd_addr[1:0])
                    2'b00: rd_d.data = {8'h00, MFR_CODE};
                    2'b01: rd_d.data = {(byte_mode ? 8'h00 : DEV_HI), DEV_LO};
                    2'b10: rd_d.data = {{(DATA_W-1){1'b0}}, sect_lock};
                    default: rd_d.data = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;

    // R8
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    // R8
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && rd_data == '0));
endmodule

// File: rtl/sg_pe_gate.sv
module sg_pe_gate
    import sg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pe_req,
    input  sect_t            pe_sect,
    input  logic             hv_reset,
    input  logic [NSECT-1:0] lock,
    output logic             pe_grant,
    output logic             pe_reject
);
    typedef struct packed {
        logic grant;
        logic reject;
    } pe_st_t;

    pe_st_t pe_d, pe_q;
    logic   locked_now;

    assign locked_now = lock[pe_sect];

    always_comb begin
        pe_d        = '0;
        pe_d.grant  = pe_req && (!locked_now || hv_reset);
        pe_d.reject = pe_req && locked_now && !hv_reset;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pe_q <= '0;
        else        pe_q <= pe_d;
    end

    assign pe_grant  = pe_q.grant;
    assign pe_reject = pe_q.reject;

    // R11
    locked_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_req && !hv_reset && locked_now) |=> (pe_reject && !pe_grant));
    // R10
    pe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pe_req |=> (!pe_grant && !pe_reject));
endmodule

// File: rtl/sect_guard.sv
module sect_guard
    import sg_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_reset,
    input  logic              byte_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pe_req,
    input  logic [ADDR_W-1:0] pe_addr,
    output logic              pe_grant,
    output logic              pe_reject
);
    sect_t            wr_sect, rd_sect, pe_sect;
    logic [NSECT-1:0] lock;
    logic             vfy;
    addr_t            vaddr;

    sg_sector_map #(.TOP_BOOT(TOP_BOOT)) i_map_wr (.addr(wr_addr), .sect(wr_sect));
    sg_sector_map #(.TOP_BOOT(TOP_BOOT)) i_map_rd (.addr(rd_addr), .sect(rd_sect));
    sg_sector_map #(.TOP_BOOT(TOP_BOOT)) i_map_pe (.addr(pe_addr), .sect(pe_sect));

    sg_cmd i_cmd (
        .clk(clk), .rst_n(rst_n), .hv_reset(hv_reset),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_sect(wr_sect),
        .rd_en(rd_en), .lock_o(lock), .vfy_o(vfy), .vaddr_o(vaddr)
    );

    sg_rdmux #(.TOP_BOOT(TOP_BOOT)) i_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_sect(rd_sect), .byte_mode(byte_mode), .lock(lock), .vfy(vfy),
        .vaddr(vaddr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    sg_pe_gate i_pe (
        .clk(clk), .rst_n(rst_n), .pe_req(pe_req), .pe_sect(pe_sect),
        .hv_reset(hv_reset), .lock(lock), .pe_grant(pe_grant), .pe_reject(pe_reject)
    );
endmodule

// File: tb/test_sect_guard.sv
module test_sect_guard;
    localparam bit TOP_BOOT = 1'b1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hv_reset = 1'b0, byte_mode = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, pe_req = 1'b0;
    logic [18:0] wr_addr = '0, rd_addr = '0, pe_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_valid, pe_grant, pe_reject;
    logic [15:0] rd_data;

    logic hv_next = 1'b0, bm_next = 1'b0;
    int   checks = 0, fails = 0, cycles = 0;
    string cur_req = "R1";
    bit   run_cmp = 1'b0;

    always #2 clk = ~clk;

    sect_guard #(.TOP_BOOT(TOP_BOOT)) i_sect_guard (
        .clk(clk), .rst_n(rst_n), .hv_reset(hv_reset), .byte_mode(byte_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .pe_req(pe_req), .pe_addr(pe_addr), .pe_grant(pe_grant), .pe_reject(pe_reject)
    );

    // behavioural reference model
    bit lk[19];
    bit seq_m, vf_m;
    int vaddr_m;
    bit exp_valid, exp_grant, exp_rej;
    int exp_data;

    function automatic int sect_of(int a);
        if (TOP_BOOT) begin
            if (a < 'h78000) return a / 'h8000;
            if (a < 'h7C000) return 15;
            if (a < 'h7D000) return 16;
            if (a < 'h7E000) return 17;
            return 18;
        end else begin
            if (a < 'h2000) return 0;
            if (a < 'h3000) return 1;
            if (a < 'h4000) return 2;
            if (a < 'h8000) return 3;
            return a / 'h8000 + 3;
        end
    endfunction

    function automatic int base_of(int s);
        if (TOP_BOOT) begin
            if (s < 15) return s * 'h8000;
            if (s == 15) return 'h78000;
            if (s == 16) return 'h7C000;
            if (s == 17) return 'h7D000;
            return 'h7E000;
        end else begin
            if (s == 0) return 0;
            if (s == 1) return 'h2000;
            if (s == 2) return 'h3000;
            if (s == 3) return 'h4000;
            return (s - 3) * 'h8000;
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (lk[i]) lk[i] = 1'b0;
            seq_m = 0; vf_m = 0; vaddr_m = 0;
            exp_valid = 0; exp_data = 0; exp_grant = 0; exp_rej = 0;
        end else begin
            bit all_l;
            all_l = 1'b1;
            foreach (lk[i]) if (!lk[i]) all_l = 1'b0;
            exp_valid = rd_en;
            exp_data  = 0;
            if (rd_en) begin
                if (vf_m && int'(rd_addr) == vaddr_m) exp_data = lk[sect_of(int'(rd_addr))];
                else if (!rd_addr[6]) begin
                    case (rd_addr[1:0])
                        2'd0: exp_data = 'h0001;
                        2'd1: exp_data = (byte_mode ? 0 : 'h2200) + (TOP_BOOT ? 'hDA : 'h5B);
                        2'd2: exp_data = lk[sect_of(int'(rd_addr))];
                        default: exp_data = 0;
                    endcase
                end
            end
            exp_grant = pe_req && (!lk[sect_of(int'(pe_addr))] || hv_reset);
            exp_rej   = pe_req && !exp_grant;
            if (rd_en && vf_m) vf_m = 0;
            if (!hv_reset) begin
                seq_m = 0; vf_m = 0;
            end else if (wr_en) begin
                bit pat;
                pat = (wr_addr[1:0] == 2'b10);
                if (wr_data == 8'h60 && pat) begin
                    seq_m = 1;
                    if (!wr_addr[6]) lk[sect_of(int'(wr_addr))] = 1'b1;
                    else if (all_l) foreach (lk[i]) lk[i] = 1'b0;
                end else if (wr_data == 8'h40 && pat && seq_m) begin
                    vf_m = 1; vaddr_m = int'(wr_addr);
                end else if (wr_data == 8'hF0) begin
                    seq_m = 0; vf_m = 0;
                end
            end
        end
    end

    task automatic chk(string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL [%s] %s got %h expected %h at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run_cmp) begin
            chk("rd_valid (R8)", int'(rd_valid), int'(exp_valid));
            chk("rd_data (R7)", int'(rd_data), exp_data);
            chk("pe_grant (R10)", int'(pe_grant), int'(exp_grant));
            chk("pe_reject (R10)", int'(pe_reject), int'(exp_rej));
        end
    end

    task automatic step(bit w, int wa, int wd, bit r, int ra, bit p, int pa);
        @(negedge clk); #1;
        hv_reset = hv_next; byte_mode = bm_next;
        wr_en = w; wr_addr = 19'(wa); wr_data = 8'(wd);
        rd_en = r; rd_addr = 19'(ra);
        pe_req = p; pe_addr = 19'(pa);
    endtask
    task automatic wr(int a, int d); step(1, a, d, 0, 0, 0, 0); endtask
    task automatic rd(int a);        step(0, 0, 0, 1, a, 0, 0); endtask
    task automatic pe(int a);        step(0, 0, 0, 0, 0, 1, a); endtask
    task automatic idle();           step(0, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        run_cmp = 1'b1;
        // R1: reset state and all sectors open
        cur_req = "R1";
        idle();
        for (int s = 0; s < 19; s++) begin rd(base_of(s) | 2); pe(base_of(s)); end
        // R3: command without high voltage does nothing
        cur_req = "R3";
        wr(base_of(3) | 2, 'h60); pe(base_of(3)); rd(base_of(3) | 2);
        // R4 and R6: lock, verify, read back
        cur_req = "R4";
        hv_next = 1; idle();
        wr(base_of(5) | 2, 'h60); rd(base_of(5) | 2);
        cur_req = "R6";
        wr(base_of(5) | 2, 'h40); rd(base_of(5) | 2); rd(base_of(5) | 2);
        wr(base_of(7) | 'h42, 'h40); rd(base_of(7) | 'h42);
        // R11: temporary override, then restore
        cur_req = "R11";
        pe(base_of(5)); hv_next = 0; pe(base_of(5)); pe(base_of(6));
        // R3: dropping the flag closed the sequence
        cur_req = "R3";
        hv_next = 1; wr(base_of(5) | 2, 'h40); rd(base_of(5) | 2);
        // R5: refused release while not all locked
        cur_req = "R5";
        wr(base_of(0) | 'h42, 'h60); rd(base_of(5) | 2);
        for (int s = 0; s < 19; s++) wr(base_of(s) | 2, 'h60);
        for (int s = 0; s < 19; s++) rd(base_of(s) | 2);
        wr(base_of(2) | 'h42, 'h60);
        for (int s = 0; s < 19; s++) rd(base_of(s) | 2);
        // R9: exit command drops a pending verify
        cur_req = "R9";
        wr(base_of(9) | 2, 'h60); wr(base_of(9) | 'h42, 'h40); wr(0, 'hF0);
        rd(base_of(9) | 'h42); wr(base_of(9) | 'h42, 'h40); rd(base_of(9) | 'h42);
        // R7: identifier decode in both width modes
        cur_req = "R7";
        hv_next = 0;
        for (int b = 0; b < 2; b++) begin
            bm_next = b[0];
            for (int k = 0; k < 4; k++) begin rd(k); rd('h40 | k); end
        end
        bm_next = 0;
        // R2: sector boundaries around the small sectors
        cur_req = "R2";
        hv_next = 1; wr(base_of(16) | 2, 'h60); hv_next = 0;
        pe('h7BFFF); pe('h7C000); pe('h7CFFF); pe('h7D000); pe('h7DFFF); pe('h7E000);
        pe('h00000); pe('h01FFF); pe('h02000); pe('h03FFF); pe('h04000); pe('h08000);
        // R10: random traffic against the model
        cur_req = "R10";
        for (int n = 0; n < 3000; n++) begin
            int s, op, pat;
            int pats[6] = '{0, 1, 2, 3, 'h40, 'h42};
            int ops[4]  = '{'h60, 'h40, 'hF0, 'h13};
            if ($urandom_range(0, 15) == 0) hv_next = ~hv_next;
            bm_next = $urandom_range(0, 1);
            s = $urandom_range(0, 18); op = ops[$urandom_range(0, 3)];
            pat = pats[$urandom_range(0, 5)];
            step($urandom_range(0, 1), base_of(s) | pat, op,
                 $urandom_range(0, 1), base_of($urandom_range(0, 18)) | pats[$urandom_range(0, 5)],
                 $urandom_range(0, 1), base_of($urandom_range(0, 18)) + $urandom_range(0, 'hFFF));
        end
        idle(); idle();
        @(negedge clk);
        run_cmp = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL [watchdog] run did not finish, cycles %0d expected below %0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule